// File: doc/BRIEF.md
# Auto-Negotiation Restart and Parallel-Detect Controller

This block sequences the auto-negotiation function of a 10/100 Ethernet transceiver. Management control bits enable negotiation and request a restart. A restart request, or loss of the link that negotiation produced, starts a quiet interval. During that interval the transmitter is held off and no link pulses are sent. When the interval ends, fast link pulse bursts are enabled again and the block waits for a result.

There are two ways to reach a result. The first is a partner that negotiates: its received base page is stored and the partner-negotiates flag is set. The second is parallel detection: exactly one technology link monitor (10 Mb/s or 100 Mb/s) reports a good link. The block then stores a fixed ability word and clears the partner-negotiates flag. If both monitors report a good link at the same time, a sticky fault is raised, and a status read clears it.

If the device strapped up in forced mode, negotiation stays off until the enable bit has been seen low and then high.

Top module: `anr_top`

## Requirements
- R1: During and after a synchronous reset (rstN low), flpEnable, txInhibit, anComplete, lpNegAble, pdFault are 0 and lpAbility is 0.
- R2: With anEnable high and the block active (burst, quiet or complete phase), an anRestart pulse makes txInhibit 1 and flpEnable, anComplete, lpNegAble and lpAbility 0 from the next cycle on.
- R3: The quiet phase ends at the clock edge that sees the BREAK_TICKS-th tick counted since the phase began. From the next cycle on, flpEnable is 1 and txInhibit is 0. Without ticks the quiet phase persists.
- R4: An anRestart during the quiet phase restarts the tick count from zero. The restart wins over a simultaneous final tick.
- R5: In the complete phase, linkValid low causes a restart: txInhibit is 1 in the next cycle.
- R6: In the burst phase, if exactly one of linkGood10 and linkGood100 is high, the next cycle shows anComplete 1 and lpNegAble 0. lpAbility then holds 0x0001 in bits 4:0, bit 5 equal to linkGood10, bit 7 equal to linkGood100, and zeros elsewhere. This gives 0x0021 for 10 Mb/s and 0x0081 for 100 Mb/s.
- R7: In the burst phase, partnerFlp high loads lpAbility with partnerPage and sets lpNegAble and anComplete in the next cycle. partnerFlp takes priority over the link monitors.
- R8: In the burst phase, linkGood10 and linkGood100 both high (with partnerFlp low) set pdFault in the next cycle. The block stays in the burst phase, and pdFault holds until it is read.
- R9: statusRead clears pdFault in the next cycle, unless a new fault condition occurs in the same cycle, in which case pdFault stays 1.
- R10: If strapForced is high during reset, anEnable high has no effect until anEnable has been seen low in at least one cycle. With strapForced low, anEnable high starts the burst phase in the next cycle.
- R11: anEnable low returns the block to idle in the next cycle, with all outputs 0. An anRestart while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| strapForced | input | 1 | Forced-mode strap, sampled during reset |
| anEnable | input | 1 | Negotiation enable control bit |
| anRestart | input | 1 | Restart request strobe, one cycle |
| linkGood10 | input | 1 | 10 Mb/s link monitor reports good link |
| linkGood100 | input | 1 | 100 Mb/s link monitor reports good link |
| partnerFlp | input | 1 | Negotiating partner page received and accepted |
| partnerPage | input | LP_W | Partner base page received |
| linkValid | input | 1 | Link resolved by negotiation is still valid |
| tick | input | 1 | Timebase tick for the quiet interval |
| statusRead | input | 1 | Status register read strobe (clears fault) |
| flpEnable | output | 1 | Enable fast link pulse bursts |
| txInhibit | output | 1 | Suppress transmit data and link pulses |
| anComplete | output | 1 | Negotiation complete |
| lpAbility | output | LP_W | Link partner ability word |
| lpNegAble | output | 1 | Partner negotiates (0 after parallel detection) |
| pdFault | output | 1 | Sticky parallel-detect fault |

## Verification
The properties assume that all inputs change only between clock edges. They also assume that anRestart and statusRead are single-cycle strobes whose effect is judged at one edge. They do not assume that the link monitors are mutually exclusive, because both reporting a good link at once is the fault case. The stimulus drives every input at the falling edge. It keeps anEnable high most of the time and makes restarts and partner pages rare, so that each phase is reached and left by every path. It deliberately raises both link monitors together to provoke the fault.

// File: rtl/anr_pkg.sv
package anr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_BREAK   = 2'd1,
    ST_ABILITY = 2'd2,
    ST_DONE    = 2'd3
  } anState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadBreak;  // restart quiet interval count
    logic breakTick;  // count one tick of quiet interval
    logic loadPd;     // store parallel-detect ability word
    logic loadFlp;    // store partner page
    logic clearLp;    // clear partner ability state
    logic setFault;   // raise parallel-detect fault
  } anStrobe_t;

endpackage

// File: rtl/anr_ctrl.sv
module anr_ctrl
  import anr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      strapForced,
  input  logic      anEnable,
  input  logic      anRestart,
  input  logic      linkGood10,
  input  logic      linkGood100,
  input  logic      partnerFlp,
  input  logic      linkValid,
  input  logic      tick,
  input  logic      breakDone,
  output anStrobe_t stb,
  output logic      flpEnable,
  output logic      txInhibit,
  output logic      anComplete
);

  anState_t st, nxt;
  logic     forcedLock;
  logic     oneGood, bothGood;

  assign oneGood  = linkGood10 ^ linkGood100;
  assign bothGood = linkGood10 & linkGood100;

  // forced strap holds negotiation off until enable has been seen low
  always_ff @(posedge clk) begin
    if (!rstN)          forcedLock <= strapForced;
    else if (!anEnable) forcedLock <= 1'b0;
  end

  always_comb begin
    nxt = st;
    stb = '0;
    stb.breakTick = (st == ST_BREAK) && tick;
    if (st == ST_IDLE) begin
      if (anEnable && !forcedLock) begin
        nxt = ST_ABILITY;
        stb.clearLp = 1'b1;
      end
    end else if (!anEnable) begin
      nxt = ST_IDLE;
      stb.clearLp = 1'b1;
    end else if (anRestart) begin
      nxt = ST_BREAK;
      stb.loadBreak = 1'b1;
      stb.clearLp = 1'b1;
    end else begin
      case (st)
        ST_BREAK: begin
          if (breakDone) nxt = ST_ABILITY;
        end
        ST_ABILITY: begin
          if (partnerFlp) begin
            nxt = ST_DONE;
            stb.loadFlp = 1'b1;
          end else if (oneGood) begin
            nxt = ST_DONE;
            stb.loadPd = 1'b1;
          end else if (bothGood) begin
            stb.setFault = 1'b1;
          end
        end
        ST_DONE: begin
          if (!linkValid) begin
            nxt = ST_BREAK;
            stb.loadBreak = 1'b1;
            stb.clearLp = 1'b1;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  assign flpEnable  = (st == ST_ABILITY);
  assign txInhibit  = (st == ST_BREAK);
  assign anComplete = (st == ST_DONE);

endmodule

// File: rtl/anr_datapath.sv
module anr_datapath
  import anr_pkg::*;
#(
  parameter int BREAK_TICKS = 1500,
  parameter int LP_W        = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  anStrobe_t       stb,
  input  logic            linkGood10,
  input  logic            linkGood100,
  input  logic [LP_W-1:0] partnerPage,
  input  logic            statusRead,
  output logic            breakDone,
  output logic [LP_W-1:0] lpAbility,
  output logic            lpNegAble,
  output logic            pdFault
);

  localparam int CNT_W = (BREAK_TICKS > 1) ? $clog2(BREAK_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BREAK_TICKS - 1);
  localparam logic [4:0] SEL_CODE = 5'b00001;
  localparam int BIT_10M  = 5;
  localparam int BIT_100M = 7;

  logic [CNT_W-1:0] breakCnt;
  logic [LP_W-1:0]  pdWord;

  // quiet interval tick counter
  always_ff @(posedge clk) begin
    if (!rstN)              breakCnt <= '0;
    else if (stb.loadBreak) breakCnt <= '0;
    else if (stb.breakTick) breakCnt <= breakCnt + 1'b1;
  end

  assign breakDone = stb.breakTick && (breakCnt == LAST_CNT);

  always_comb begin
    pdWord = '0;
    pdWord[4:0]      = SEL_CODE;
    pdWord[BIT_10M]  = linkGood10;
    pdWord[BIT_100M] = linkGood100;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lpAbility <= '0;
      lpNegAble <= 1'b0;
    end else if (stb.loadFlp) begin
      lpAbility <= partnerPage;
      lpNegAble <= 1'b1;
    end else if (stb.loadPd) begin
      lpAbility <= pdWord;
      lpNegAble <= 1'b0;
    end else if (stb.clearLp) begin
      lpAbility <= '0;
      lpNegAble <= 1'b0;
    end
  end

  // sticky fault, read-to-clear, set wins
  always_ff @(posedge clk) begin
    if (!rstN)             pdFault <= 1'b0;
    else if (stb.setFault) pdFault <= 1'b1;
    else if (statusRead)   pdFault <= 1'b0;
  end

endmodule

// File: rtl/anr_top.sv
module anr_top
  import anr_pkg::*;
#(
  parameter int BREAK_TICKS = 1500,
  parameter int LP_W        = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            strapForced,
  input  logic            anEnable,
  input  logic            anRestart,
  input  logic            linkGood10,
  input  logic            linkGood100,
  input  logic            partnerFlp,
  input  logic [LP_W-1:0] partnerPage,
  input  logic            linkValid,
  input  logic            tick,
  input  logic            statusRead,
  output logic            flpEnable,
  output logic            txInhibit,
  output logic            anComplete,
  output logic [LP_W-1:0] lpAbility,
  output logic            lpNegAble,
  output logic            pdFault
);

  anStrobe_t stb;
  logic      breakDone;

  anr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .strapForced(strapForced),
    .anEnable(anEnable), .anRestart(anRestart),
    .linkGood10(linkGood10), .linkGood100(linkGood100),
    .partnerFlp(partnerFlp), .linkValid(linkValid), .tick(tick),
    .breakDone(breakDone), .stb(stb),
    .flpEnable(flpEnable), .txInhibit(txInhibit), .anComplete(anComplete)
  );

  anr_datapath #(.BREAK_TICKS(BREAK_TICKS), .LP_W(LP_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .linkGood10(linkGood10), .linkGood100(linkGood100),
    .partnerPage(partnerPage), .statusRead(statusRead),
    .breakDone(breakDone), .lpAbility(lpAbility),
    .lpNegAble(lpNegAble), .pdFault(pdFault)
  );

endmodule

// File: rtl/anr_checker.sv
module anr_checker #(
  parameter int LP_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            strapForced,
  input logic            anEnable,
  input logic            anRestart,
  input logic            linkGood10,
  input logic            linkGood100,
  input logic            partnerFlp,
  input logic [LP_W-1:0] partnerPage,
  input logic            linkValid,
  input logic            tick,
  input logic            statusRead,
  input logic            flpEnable,
  input logic            txInhibit,
  input logic            anComplete,
  input logic [LP_W-1:0] lpAbility,
  input logic            lpNegAble,
  input logic            pdFault
);

  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |=> !flpEnable && !txInhibit && !anComplete && !pdFault && !lpNegAble);

  a_r10_forced_hold: assert property (@(posedge clk)
    (!rstN && strapForced) |=> !flpEnable && !txInhibit);

  a_r2_restart_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (anEnable && anRestart && (flpEnable || txInhibit || anComplete)) |=> txInhibit && !lpNegAble);

  a_r3_no_tick_stays: assert property (@(posedge clk) disable iff (!rstN)
    (txInhibit && anEnable && !tick) |=> txInhibit);

  a_r5_link_loss: assert property (@(posedge clk) disable iff (!rstN)
    (anComplete && anEnable && !linkValid) |=> txInhibit);

  a_r6_pd_word: assert property (@(posedge clk) disable iff (!rstN)
    (anComplete && !lpNegAble) |-> (lpAbility == LP_W'(16'h0021) || lpAbility == LP_W'(16'h0081)));

  a_r7_page_load: assert property (@(posedge clk) disable iff (!rstN)
    (flpEnable && anEnable && !anRestart && partnerFlp) |=>
      (lpNegAble && anComplete && lpAbility == $past(partnerPage)));

  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (pdFault && !statusRead) |=> pdFault);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !(flpEnable && anEnable && !anRestart && !partnerFlp && linkGood10 && linkGood100))
      |=> !pdFault);

  a_r11_disabled_idle: assert property (@(posedge clk) disable iff (!rstN)
    !anEnable |=> !flpEnable && !txInhibit && !anComplete);

endmodule

bind anr_top anr_checker #(.LP_W(LP_W)) u_chk (.*);

// File: tb/sim_anr_top.sv
`timescale 1ns/1ps
module sim_anr_top;

  localparam int BT   = 5;
  localparam int LP_W = 16;

  logic clk = 1'b0;
  logic rstN, strapForced, anEnable, anRestart, linkGood10, linkGood100;
  logic partnerFlp, linkValid, tick, statusRead;
  logic [LP_W-1:0] partnerPage;
  logic flpEnable, txInhibit, anComplete, lpNegAble, pdFault;
  logic [LP_W-1:0] lpAbility;

  always #10 clk = ~clk;  // 50 MHz

  anr_top #(.BREAK_TICKS(BT), .LP_W(LP_W)) u0 (.*);

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model from the requirements: 0 idle,1 quiet,2 burst,3 complete
  int mState = 0, mCnt = 0;
  bit mLock = 0, mAble = 0, mFault = 0;
  logic [LP_W-1:0] mLp = '0;

  function automatic logic [LP_W-1:0] pdWordOf(logic g10, logic g100);
    logic [LP_W-1:0] w;
    w = LP_W'(16'h0001);
    w[5] = g10;
    w[7] = g100;
    return w;
  endfunction

  task automatic toQuiet();
    mState = 1; mCnt = 0; mLp = '0; mAble = 0;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mLock = strapForced; mAble = 0; mFault = 0; mLp = '0;
    end else begin
      bit setF;
      setF = 0;
      if (mState == 0) begin
        if (anEnable && !mLock) begin mState = 2; mLp = '0; mAble = 0; end
      end else if (!anEnable) begin
        mState = 0; mLp = '0; mAble = 0;
      end else if (anRestart) begin
        toQuiet();
      end else if (mState == 1) begin
        if (tick) begin
          mCnt++;
          if (mCnt == BT) mState = 2;
        end
      end else if (mState == 2) begin
        if (partnerFlp) begin mState = 3; mLp = partnerPage; mAble = 1; end
        else if (linkGood10 ^ linkGood100) begin
          mState = 3; mLp = pdWordOf(linkGood10, linkGood100); mAble = 0;
        end else if (linkGood10 && linkGood100) setF = 1;
      end else if (mState == 3) begin
        if (!linkValid) toQuiet();
      end
      if (setF) mFault = 1;
      else if (statusRead) mFault = 0;
      if (!anEnable) mLock = 0;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R4 model flpEnable", 32'(flpEnable), 32'(mState == 2));
      check("R2 model txInhibit", 32'(txInhibit), 32'(mState == 1));
      check("R5 model anComplete", 32'(anComplete), 32'(mState == 3));
      check("R6 model lpAbility", 32'(lpAbility), 32'(mLp));
      check("R7 model lpNegAble", 32'(lpNegAble), 32'(mAble));
      check("R9 model pdFault", 32'(pdFault), 32'(mFault));
    end
  end

  task automatic idleInputs();
    anRestart = 0; linkGood10 = 0; linkGood100 = 0; partnerFlp = 0;
    tick = 0; statusRead = 0; linkValid = 1; partnerPage = '0;
  endtask

  initial begin
    rstN = 0; strapForced = 1; anEnable = 1;
    idleInputs();
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {flpEnable, txInhibit, anComplete, lpNegAble, pdFault}, 0);
    check("R1 reset lpAbility", 32'(lpAbility), 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    check("R10 forced strap holds idle", 32'(flpEnable), 0);
    anEnable = 0; @(negedge clk);
    anEnable = 1; @(negedge clk);
    check("R10 enable after clear starts bursts", 32'(flpEnable), 1);

    linkGood100 = 1; @(negedge clk);
    check("R6 pd 100M complete", 32'(anComplete), 1);
    check("R6 pd 100M word", 32'(lpAbility), 32'h0081);
    check("R6 pd negAble zero", 32'(lpNegAble), 0);

    linkValid = 0; linkGood100 = 0; @(negedge clk);
    check("R5 link loss quiet", 32'(txInhibit), 1);
    check("R5 link loss clears word", 32'(lpAbility), 0);
    linkValid = 1;

    tick = 1;
    repeat (BT - 1) @(negedge clk);
    check("R3 still quiet before last tick", 32'(txInhibit), 1);
    @(negedge clk);
    check("R3 bursts after last tick", {flpEnable, txInhibit}, 32'b10);
    tick = 0;

    linkGood10 = 1; linkGood100 = 1; @(negedge clk);
    check("R8 both good fault", 32'(pdFault), 1);
    check("R8 stays in bursts", 32'(flpEnable), 1);
    linkGood10 = 0; linkGood100 = 0; @(negedge clk);
    check("R8 fault sticky", 32'(pdFault), 1);
    statusRead = 1; @(negedge clk);
    statusRead = 0;
    check("R9 read clears fault", 32'(pdFault), 0);

    partnerFlp = 1; partnerPage = 16'hA5E1; @(negedge clk);
    partnerFlp = 0;
    check("R7 page stored", 32'(lpAbility), 32'hA5E1);
    check("R7 negAble set", 32'(lpNegAble), 1);

    anRestart = 1; @(negedge clk);
    anRestart = 0;
    check("R2 restart quiet", {txInhibit, anComplete, lpNegAble}, 32'b100);
    tick = 1;
    repeat (3) @(negedge clk);
    anRestart = 1; @(negedge clk);
    anRestart = 0;
    repeat (BT - 1) @(negedge clk);
    check("R4 reload keeps quiet", 32'(txInhibit), 1);
    @(negedge clk);
    check("R4 bursts after reloaded count", 32'(flpEnable), 1);
    tick = 0;

    linkGood10 = 1; @(negedge clk);
    linkGood10 = 0;
    check("R6 pd 10M word", 32'(lpAbility), 32'h0021);

    anEnable = 0; @(negedge clk);
    check("R11 disable idles", {flpEnable, txInhibit, anComplete}, 0);
    anRestart = 1; @(negedge clk);
    anRestart = 0;
    check("R11 restart ignored while idle", 32'(txInhibit), 0);
    anEnable = 1; @(negedge clk);

    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      anEnable    = ($urandom % 40) != 0;
      anRestart   = ($urandom % 25) == 0;
      tick        = ($urandom % 2) == 0;
      linkGood10  = ($urandom % 6) == 0;
      linkGood100 = ($urandom % 6) == 0;
      partnerFlp  = ($urandom % 15) == 0;
      partnerPage = LP_W'($urandom);
      linkValid   = ($urandom % 12) != 0;
      statusRead  = ($urandom % 8) == 0;
      @(negedge clk);
    end

    rstN = 0; strapForced = 0; idleInputs(); anEnable = 1;
    @(negedge clk);
    rstN = 1; @(negedge clk);
    check("R10 unforced enable starts bursts", 32'(flpEnable), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule